// File: doc/BRIEF.md
# SD Card SPI Host Port

This block is a byte-wide SPI master that a CPU drives through four 8-bit I/O ports. It serves two SD card slots. Software loads an outgoing byte into the data port, touches the start port to launch one full-duplex 8-bit exchange, polls the status port until the busy flag drops, and then reads the received byte back from the data port. A rate port chooses between a slow serial clock for card initialization and a fast one for sector traffic. A select port drives the two active-low card selects directly, with no hardware sequencing.

The exchange engine is a three-state machine. `ENG_IDLE` holds SCK low and MOSI high. A start access moves it to `ENG_LOW` (the *launch* transition). It latches the outgoing byte and the phase lengths of the current rate and puts the MSB on MOSI. When the low-phase counter expires, the *rise* transition moves it to `ENG_HIGH`, raises SCK and samples MISO. When the high-phase counter expires, the *fall* transition returns it to `ENG_LOW` with the next bit on MOSI. After the eighth bit, the *finish* transition returns it to `ENG_IDLE` and publishes the received byte. The slow and fast rates are each set by a low-phase and a high-phase length in system clocks, given as parameters. With a 50 MHz system clock the defaults give about 167 kHz and 10 MHz.

Top module: `sdspi_host`

## Requirements
- R1: After reset SCK is 0, MOSI is 1, both card selects read 1, the status port (index 1) reads 0x00 and the data port (index 0) reads 0xFF.
- R2: A write to the select port (index 2) drives `spi_cs_n[1:0]` from write bits 1:0 from the next cycle on. A 0 asserts a card. Reading index 2 returns these bits in bits 1:0.
- R3: Any access to the start port (index 3), read or write, starts an exchange when idle. Status bit 0 (busy) reads 1 from the cycle after that access.
- R4: Each exchange sends the byte last written to index 0, MSB first, in SPI mode 0. MOSI changes only while SCK is low. SCK idles low and MOSI idles high.
- R5: MISO is sampled on each SCK rising edge, MSB first. After busy clears, index 0 reads the received byte.
- R6: Each bit has a low phase of LO cycles followed by a high phase of HI cycles. (LO, HI) is (FAST_LO, FAST_HI) when status bit 1 is 1 and (SLOW_LO, SLOW_HI) when it is 0. Busy lasts exactly 8*(LO+HI) cycles.
- R7: A start access while busy is ignored: the running exchange neither restarts nor stretches.
- R8: A write to index 1 bit 0 (1 = fast, 0 = slow) during an exchange leaves that exchange's timing unchanged and applies from the next exchange on.
- R9: A write to index 0 during an exchange does not alter the bits being sent; the new byte is sent by the next exchange.
- R10: Every exchange gives exactly 8 SCK rising edges. Busy clears in the cycle that SCK returns low after the eighth high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Port access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Port index: 0 data, 1 rate/status, 2 select, 3 start |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the cards |
| spi_miso | input | 1 | Serial data from the cards |
| spi_cs_n | output | 2 | Active-low card selects |

## Verification
The bound checker watches several rules on every cycle: MOSI is held while SCK stays high, the lines are idle whenever the engine is idle, SCK is never high outside an exchange, a start access from idle always raises busy, the select lines follow each write, and every exchange ends after exactly eight rising edges. Other behaviours need the bench's scenarios and its cycle-by-cycle reference model. These are the exact phase lengths at each rate, the received byte, a start ignored mid-exchange, and rate or data writes that wait for the byte boundary.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH
    } eng_state_t;

    localparam logic [1:0] PORT_DATA = 2'd0;
    localparam logic [1:0] PORT_RATE = 2'd1;
    localparam logic [1:0] PORT_SEL  = 2'd2;
    localparam logic [1:0] PORT_GO   = 2'd3;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_FAST_BIT = 1;

endpackage

// File: rtl/sdspi_regs.sv
module sdspi_regs
    import sdspi_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           busy,
    input  logic [DW-1:0]  rx_byte,
    output logic [DW-1:0]  tx_byte,
    output logic           rate_fast,
    output logic [NCS-1:0] cs_n,
    output logic           start
);

    logic wr_data, wr_rate, wr_sel;

    assign wr_data = bus_en && bus_wr && (bus_addr == PORT_DATA);
    assign wr_rate = bus_en && bus_wr && (bus_addr == PORT_RATE);
    assign wr_sel  = bus_en && bus_wr && (bus_addr == PORT_SEL);
    assign start   = bus_en && (bus_addr == PORT_GO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte   <= '1;
            rate_fast <= 1'b0;
            cs_n      <= '1;
        end else begin
            if (wr_data) tx_byte   <= bus_wdata;
            if (wr_rate) rate_fast <= bus_wdata[0];
            if (wr_sel)  cs_n      <= bus_wdata[NCS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            PORT_DATA: bus_rdata = rx_byte;
            PORT_RATE: begin
                bus_rdata[STAT_BUSY_BIT] = busy;
                bus_rdata[STAT_FAST_BIT] = rate_fast;
            end
            PORT_SEL:  bus_rdata[NCS-1:0] = cs_n;
            PORT_GO:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sdspi_rate.sv
module sdspi_rate #(
    parameter int SLOW_LO = 150,
    parameter int SLOW_HI = 150,
    parameter int FAST_LO = 3,
    parameter int FAST_HI = 2,
    parameter int CW      = 8
) (
    input  logic          fast,
    output logic [CW-1:0] lo_len,
    output logic [CW-1:0] hi_len
);

    localparam logic [CW-1:0] SLO = CW'(SLOW_LO);
    localparam logic [CW-1:0] SHI = CW'(SLOW_HI);
    localparam logic [CW-1:0] FLO = CW'(FAST_LO);
    localparam logic [CW-1:0] FHI = CW'(FAST_HI);

    always_comb begin
        lo_len = fast ? FLO : SLO;
        hi_len = fast ? FHI : SHI;
    end

endmodule

// File: rtl/sdspi_engine.sv
module sdspi_engine
    import sdspi_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] hi_len,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic [DW-1:0] rx_byte
);

    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [BW-1:0] BIT_ONE  = BW'(1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    eng_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lo_q, hi_q;
    logic [BW-1:0] bitn;
    logic [DW-1:0] txsr, rxsr;
    logic          phase_end, last_bit;

    assign phase_end = (cnt == '0);
    assign last_bit  = (bitn == BIT_LAST);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE: if (start)     nxt = ENG_LOW;
            ENG_LOW:  if (phase_end) nxt = ENG_HIGH;
            ENG_HIGH: if (phase_end) nxt = last_bit ? ENG_IDLE : ENG_LOW;
            default:                 nxt = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // phase counter, bit counter and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            lo_q    <= CNT_ONE;
            hi_q    <= CNT_ONE;
            bitn    <= '0;
            txsr    <= '1;
            rxsr    <= '0;
            rx_byte <= '1;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        txsr <= tx_byte;
                        lo_q <= lo_len;
                        hi_q <= hi_len;
                        cnt  <= lo_len - CNT_ONE;
                        bitn <= '0;
                    end
                end
                ENG_LOW: begin
                    if (phase_end) begin
                        rxsr <= {rxsr[DW-2:0], miso};
                        cnt  <= hi_q - CNT_ONE;
                    end else begin
                        cnt  <= cnt - CNT_ONE;
                    end
                end
                ENG_HIGH: begin
                    if (phase_end) begin
                        if (last_bit) begin
                            rx_byte <= rxsr;
                        end else begin
                            txsr <= {txsr[DW-2:0], 1'b1};
                            bitn <= bitn + BIT_ONE;
                            cnt  <= lo_q - CNT_ONE;
                        end
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck  = 1'b0;
        mosi = 1'b1;
        busy = 1'b1;
        unique case (state)
            ENG_IDLE: busy = 1'b0;
            ENG_LOW:  mosi = txsr[DW-1];
            ENG_HIGH: begin
                sck  = 1'b1;
                mosi = txsr[DW-1];
            end
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdspi_host.sv
module sdspi_host #(
    parameter int DW      = 8,
    parameter int NCS     = 2,
    parameter int SLOW_LO = 150,
    parameter int SLOW_HI = 150,
    parameter int FAST_LO = 3,
    parameter int FAST_HI = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           spi_sck,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);

    localparam int MAX_SLOW = (SLOW_LO > SLOW_HI) ? SLOW_LO : SLOW_HI;
    localparam int MAX_FAST = (FAST_LO > FAST_HI) ? FAST_LO : FAST_HI;
    localparam int MAX_PH   = (MAX_SLOW > MAX_FAST) ? MAX_SLOW : MAX_FAST;
    localparam int CW       = $clog2(MAX_PH + 1);

    logic          busy, start, rate_fast;
    logic [DW-1:0] tx_byte, rx_byte;
    logic [CW-1:0] lo_len, hi_len;

    sdspi_regs #(.DW(DW), .NCS(NCS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .rate_fast (rate_fast),
        .cs_n      (spi_cs_n),
        .start     (start)
    );

    sdspi_rate #(
        .SLOW_LO (SLOW_LO), .SLOW_HI (SLOW_HI),
        .FAST_LO (FAST_LO), .FAST_HI (FAST_HI),
        .CW      (CW)
    ) u_rate (
        .fast   (rate_fast),
        .lo_len (lo_len),
        .hi_len (hi_len)
    );

    sdspi_engine #(.DW(DW), .CW(CW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_byte),
        .lo_len  (lo_len),
        .hi_len  (hi_len),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (busy),
        .rx_byte (rx_byte)
    );

endmodule

// File: rtl/sdspi_host_chk.sv
module sdspi_host_chk #(
    parameter int NCS = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           spi_sck,
    input logic           spi_mosi,
    input logic [NCS-1:0] spi_cs_n,
    input logic           busy,
    input logic           start,
    input logic           bus_en,
    input logic           bus_wr,
    input logic [1:0]     bus_addr,
    input logic [NCS-1:0] wsel
);

    logic       sck_d;
    logic [7:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sck_d <= spi_sck;
            if (start && !busy)          rise_cnt <= '0;
            else if (spi_sck && !sck_d)  rise_cnt <= rise_cnt + 8'd1;
        end
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |=> (!spi_sck || $stable(spi_mosi)));

    // R4
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!spi_sck && spi_mosi));

    // R6
    sck_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> busy);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == 2'd2) |=> (spi_cs_n == $past(wsel)));

    // R10
    eight_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt == 8'd8));

endmodule

bind sdspi_host sdspi_host_chk #(.NCS(NCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .busy     (busy),
    .start    (start),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wsel     (bus_wdata[NCS-1:0])
);

// File: tb/tb_sdspi_host.sv
module tb_sdspi_host;

    localparam int SL = 20, SH = 20, FL = 3, FH = 2;
    localparam int TS = 8 * (SL + SH);
    localparam int TF = 8 * (FL + FH);

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi;
    logic       spi_miso = 1'b1;
    logic [1:0] spi_cs_n;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    bit         m_act = 1'b0, m_fast = 1'b0;
    int         m_t = 0, m_L = SL, m_H = SH;
    logic [7:0] m_tx = 8'hFF, m_txreg = 8'hFF, m_rxsr = 8'h00, m_slv = 8'hFF;
    logic [1:0] m_cs = 2'b11;

    // line monitor
    logic       sck_prev = 1'b0;
    int         rises = 0;
    logic [7:0] mosi_cap = 8'h00;

    sdspi_host #(.SLOW_LO(SL), .SLOW_HI(SH), .FAST_LO(FL), .FAST_HI(FH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_act) begin
                if ((m_t % (m_L + m_H)) == m_L - 1) m_rxsr = {m_rxsr[6:0], spi_miso};
                m_t++;
                if (m_t == 8 * (m_L + m_H)) m_act = 1'b0;
            end else if (bus_en && bus_addr == 2'd3) begin
                m_act = 1'b1;
                m_t   = 0;
                m_L   = m_fast ? FL : SL;
                m_H   = m_fast ? FH : SH;
                m_tx  = m_txreg;
            end
            if (bus_en && bus_wr) begin
                case (bus_addr)
                    2'd0: m_txreg = bus_wdata;
                    2'd1: m_fast  = bus_wdata[0];
                    2'd2: m_cs    = bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
        if (spi_sck && !sck_prev) begin
            rises++;
            mosi_cap = {mosi_cap[6:0], spi_mosi};
        end
        sck_prev = spi_sck;
    end

    // per-cycle comparison of the serial lines against the model
    always @(negedge clk) begin
        int  per, b, w;
        logic es, em;
        if (rst_n) begin
            if (m_act) begin
                per = m_L + m_H;
                b = m_t / per;
                w = m_t % per;
                es = (w >= m_L);
                em = m_tx[7-b];
                spi_miso = m_slv[7-b];
            end else begin
                es = 1'b0;
                em = 1'b1;
                spi_miso = 1'b1;
            end
            chk("R4 R6 R2 lines", {28'd0, spi_sck, spi_mosi, spi_cs_n}, {28'd0, es, em, m_cs});
        end
    end

    // one-cycle bus tasks: called at a falling edge, return at the next one
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic poll_busy(output int n, output logic first);
        logic [7:0] d;
        n = 0;
        bus_read(2'd1, d);
        first = d[0];
        while (d[0]) begin
            n++;
            bus_read(2'd1, d);
        end
    endtask

    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] slv,
                           input bit by_read, input int exp_cyc, input string rq);
        logic [7:0] d;
        int n, r0;
        logic first;
        bus_write(2'd0, tx);
        m_slv = slv;
        r0 = rises;
        if (by_read) bus_read(2'd3, d);
        else         bus_write(2'd3, 8'h00);
        poll_busy(n, first);
        chk({"R3 busy after start ", rq}, first, 1'b1);
        chk({"R6 busy cycles ", rq}, n, exp_cyc);
        chk({"R10 rising edges ", rq}, rises - r0, 8);
        chk({"R4 bits sent MSB first ", rq}, mosi_cap, tx);
        bus_read(2'd0, d);
        chk({"R5 received byte ", rq}, d, slv);
    endtask

    initial begin
        logic [7:0] d;
        int n, r0;
        logic first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 idle lines", {29'd0, spi_sck, spi_mosi, spi_cs_n[0]}, 32'b011);
        chk("R1 select reset", spi_cs_n, 2'b11);
        bus_read(2'd1, d); chk("R1 status reset", d, 8'h00);
        bus_read(2'd0, d); chk("R1 data reset", d, 8'hFF);

        bus_write(2'd2, 8'hFE); chk("R2 cs after write", spi_cs_n, 2'b10);
        bus_read(2'd2, d);      chk("R2 cs readback", d, 8'h02);
        bus_write(2'd2, 8'h01); bus_read(2'd2, d); chk("R2 cs readback", d, 8'h01);
        bus_write(2'd2, 8'h03);

        do_xfer(8'hA5, 8'h3C, 1'b0, TS, "slow write-start");
        do_xfer(8'h12, 8'hE7, 1'b1, TS, "slow read-start");

        bus_write(2'd1, 8'h01);
        bus_read(2'd1, d); chk("R6 fast rate status", d, 8'h02);
        do_xfer(8'h5A, 8'hC3, 1'b0, TF, "fast");
        bus_write(2'd2, 8'h02);
        do_xfer(8'h00, 8'hFF, 1'b1, TF, "fast zeros");

        // R7: start while busy is ignored
        bus_write(2'd0, 8'h96); m_slv = 8'h69; r0 = rises;
        bus_write(2'd3, 8'h00);
        tick(); tick(); tick();
        bus_write(2'd3, 8'h00);
        poll_busy(n, first);
        chk("R7 ignored start busy", n, TF - 4);
        chk("R7 ignored start edges", rises - r0, 8);
        bus_read(2'd0, d); chk("R7 received byte", d, 8'h69);

        // R8: rate change mid-exchange applies from the next byte
        bus_write(2'd0, 8'hF0); m_slv = 8'h0F;
        bus_write(2'd3, 8'h00);
        tick();
        bus_write(2'd1, 8'h00);
        poll_busy(n, first);
        chk("R8 running byte kept fast", n, TF - 2);
        bus_read(2'd1, d); chk("R8 rate now slow", d, 8'h00);
        do_xfer(8'h3A, 8'hB1, 1'b0, TS, "R8 next byte slow");

        // R9: data write mid-exchange waits for the next byte
        bus_write(2'd1, 8'h01);
        bus_write(2'd0, 8'h81); m_slv = 8'h55;
        bus_write(2'd3, 8'h00);
        bus_write(2'd0, 8'h7E);
        poll_busy(n, first);
        chk("R9 busy cycles", n, TF - 1);
        chk("R9 running byte unchanged", mosi_cap, 8'h81);
        m_slv = 8'hAA;
        bus_write(2'd3, 8'h00);
        poll_busy(n, first);
        chk("R9 new byte sent next", mosi_cap, 8'h7E);
        bus_read(2'd0, d); chk("R9 received byte", d, 8'hAA);

        repeat (3) tick();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule